// File: doc/BRIEF.md
# Multiply-Accumulate Chain with Timing-Error Drop Recovery

This block is a single column of multiply-accumulate stages. A partial sum moves through it one stage per clock, and each stage adds the product of its stationary weight and its activation. Every stage holds two copies of its result. One is the main register. The other is a shadow copy that stands for a sample taken half a period later. When the two disagree, the stage has suffered a timing error. The stage after it then takes the shadow value instead of the bad main value and passes it on without adding its own product. The chain keeps running: the error costs one lost contribution and never causes a stall or a replay.

An item enters as a partial sum with one activation per stage. The activations travel down the chain alongside the item. The item also carries a per-stage injection mask that corrupts a chosen stage's main register, which gives an external stimulus a way to create a main/shadow mismatch. A static fault mask takes broken stages out of the accumulation for good. The tail reports the corrected sum, a valid pulse, and the number of products dropped from that item.

Top module: `mac_chain_edrop`

## Requirements
- R1: After a synchronous reset, out_valid is 0, out_sum is 0 and out_drops is 0.
- R2: With no injection and no faults, out_sum equals in_psum plus the sum over every stage k of weight k times activation k. Weights and activations are 8-bit two's complement, and stage k uses bits [8k+7:8k] of each bus. The 24-bit result wraps modulo 2^24. A stage whose activation is zero adds nothing.
- R3: An item presented with in_valid high before clock edge 1 appears on the outputs after edge N, with out_valid high for exactly one cycle. Items may arrive on consecutive cycles and leave in the same order.
- R4: When injection bit k is set for an item and k < N-1, stage k+1 forwards the true sum that stage k computed and omits its own product. This holds when stage k+1 is itself corrupted too.
- R5: out_drops gives, for that item alone, the number of stages whose product was omitted because the stage before them flagged an error.
- R6: An injected error in the last stage is corrected at the output: out_sum is the true sum and no drop is counted.
- R7: A stage whose fault-mask bit is set contributes no product. It passes the incoming sum on unchanged, or the shadow sum if its predecessor flagged an error, and counts no drop in either case.
- R8: On cycles when out_valid is low, out_sum holds the value of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An item is presented this cycle |
| in_psum | input | 24 | Incoming partial sum |
| in_act | input | N*8 | Activations, one byte per stage |
| weights | input | N*8 | Stationary weights, one byte per stage |
| fault_mask | input | N | Stages to bypass permanently |
| inj_mask | input | N | Per-item main-register corruption, one bit per stage |
| out_valid | output | 1 | Result present |
| out_sum | output | 24 | Corrected partial sum |
| out_drops | output | clog2(N)+1 | Products dropped from this result |

## Verification
A stage that keeps a wrong shadow value, or that picks the wrong input leg, produces a wrong out_sum or out_drops. This shows at the tail exactly N edges after the affected item entered. The sum is wrong by one stage's product, or by the corruption pattern. A broken valid pipeline shows as a result in the wrong cycle or a missing result in the same N-edge window. A tail register that loads during a bubble shows as an out_sum change on the very next low-valid cycle.

// File: rtl/mac_chain_pkg.sv
package mac_chain_pkg;
    parameter int DEF_STAGES = 4;
    parameter int DEF_OP_W   = 8;
    parameter int DEF_SUM_W  = 24;
endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
    parameter int IDX = 0,
    parameter int N   = 4,
    parameter int AW  = 8,
    parameter int SW  = 24,
    parameter int CW  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            up_valid,
    input  logic [SW-1:0]   up_main,
    input  logic [SW-1:0]   up_shadow,
    input  logic            up_err,
    input  logic [CW-1:0]   up_drops,
    input  logic [N*AW-1:0] up_acts,
    input  logic [N-1:0]    up_inj,
    input  logic [AW-1:0]   weight,
    input  logic            faulty,
    output logic            dn_valid,
    output logic [SW-1:0]   dn_main,
    output logic [SW-1:0]   dn_shadow,
    output logic            dn_err,
    output logic [CW-1:0]   dn_drops,
    output logic [N*AW-1:0] dn_acts,
    output logic [N-1:0]    dn_inj
);
    localparam int PW = 2 * AW;

    typedef struct packed {
        logic            valid;
        logic [SW-1:0]   main;
        logic [SW-1:0]   shadow;
        logic [CW-1:0]   drops;
        logic [N*AW-1:0] acts;
        logic [N-1:0]    inj;
    } stage_t;

    stage_t st_d, st_q;

    logic [AW-1:0]        act;
    logic signed [PW-1:0] prod;
    logic [SW-1:0]        prod_ext;
    logic [SW-1:0]        base;
    logic [SW-1:0]        fixed;
    logic                 take;

    always_comb begin
        act      = up_acts[IDX*AW +: AW];
        prod     = $signed(weight) * $signed(act);
        prod_ext = {{(SW-PW){prod[PW-1]}}, prod};
        // error mux: predecessor's shadow replaces its main on a mismatch
        base     = up_err ? up_shadow : up_main;
        // zero activation, faulty stage or recovery cycle bypass the multiplier
        take     = !faulty && !up_err && (act != '0);
        fixed    = take ? (base + prod_ext) : base;

        st_d       = st_q;
        st_d.valid = up_valid;
        if (up_valid) begin
            st_d.shadow = fixed;
            st_d.main   = up_inj[IDX] ? ~fixed : fixed;
            st_d.drops  = up_drops + CW'(up_err && !faulty);
            st_d.acts   = up_acts;
            st_d.inj    = up_inj;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dn_valid  = st_q.valid;
    assign dn_main   = st_q.main;
    assign dn_shadow = st_q.shadow;
    assign dn_err    = (st_q.main != st_q.shadow);
    assign dn_drops  = st_q.drops;
    assign dn_acts   = st_q.acts;
    assign dn_inj    = st_q.inj;
endmodule

// File: rtl/out_pick.sv
module out_pick #(
    parameter int SW = 24,
    parameter int CW = 3
) (
    input  logic          tail_valid,
    input  logic [SW-1:0] tail_main,
    input  logic [SW-1:0] tail_shadow,
    input  logic          tail_err,
    input  logic [CW-1:0] tail_drops,
    output logic          out_valid,
    output logic [SW-1:0] out_sum,
    output logic [CW-1:0] out_drops
);
    always_comb begin
        out_valid = tail_valid;
        out_sum   = tail_err ? tail_shadow : tail_main;
        out_drops = tail_drops;
    end
endmodule

// File: rtl/mac_chain_edrop.sv
module mac_chain_edrop #(
    parameter int N  = mac_chain_pkg::DEF_STAGES,
    parameter int AW = mac_chain_pkg::DEF_OP_W,
    parameter int SW = mac_chain_pkg::DEF_SUM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SW-1:0]     in_psum,
    input  logic [N*AW-1:0]   in_act,
    input  logic [N*AW-1:0]   weights,
    input  logic [N-1:0]      fault_mask,
    input  logic [N-1:0]      inj_mask,
    output logic              out_valid,
    output logic [SW-1:0]     out_sum,
    output logic [$clog2(N):0] out_drops
);
    localparam int CW = $clog2(N) + 1;

    logic [N-1:0]                 up_v, v_w, up_e, e_w;
    logic [N-1:0][SW-1:0]         up_m, up_s, m_w, s_w;
    logic [N-1:0][CW-1:0]         up_d, d_w;
    logic [N-1:0][N*AW-1:0]       up_a, a_w;
    logic [N-1:0][N-1:0]          up_j, j_w;

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign up_v[i] = in_valid;
            assign up_m[i] = in_psum;
            assign up_s[i] = in_psum;
            assign up_e[i] = 1'b0;
            assign up_d[i] = '0;
            assign up_a[i] = in_act;
            assign up_j[i] = inj_mask;
        end else begin : g_link
            assign up_v[i] = v_w[i-1];
            assign up_m[i] = m_w[i-1];
            assign up_s[i] = s_w[i-1];
            assign up_e[i] = e_w[i-1];
            assign up_d[i] = d_w[i-1];
            assign up_a[i] = a_w[i-1];
            assign up_j[i] = j_w[i-1];
        end

        mac_stage #(.IDX(i), .N(N), .AW(AW), .SW(SW), .CW(CW)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .up_valid  (up_v[i]),
            .up_main   (up_m[i]),
            .up_shadow (up_s[i]),
            .up_err    (up_e[i]),
            .up_drops  (up_d[i]),
            .up_acts   (up_a[i]),
            .up_inj    (up_j[i]),
            .weight    (weights[i*AW +: AW]),
            .faulty    (fault_mask[i]),
            .dn_valid  (v_w[i]),
            .dn_main   (m_w[i]),
            .dn_shadow (s_w[i]),
            .dn_err    (e_w[i]),
            .dn_drops  (d_w[i]),
            .dn_acts   (a_w[i]),
            .dn_inj    (j_w[i])
        );
    end

    logic unused_tail;
    assign unused_tail = ^{a_w[N-1], j_w[N-1]};

    out_pick #(.SW(SW), .CW(CW)) u_pick (
        .tail_valid  (v_w[N-1]),
        .tail_main   (m_w[N-1]),
        .tail_shadow (s_w[N-1]),
        .tail_err    (e_w[N-1]),
        .tail_drops  (d_w[N-1]),
        .out_valid   (out_valid),
        .out_sum     (out_sum),
        .out_drops   (out_drops)
    );
endmodule

// File: rtl/mac_chain_chk.sv
module mac_chain_chk #(
    parameter int N  = 4,
    parameter int SW = 24,
    parameter int CW = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [SW-1:0]        out_sum,
    input logic [CW-1:0]        out_drops,
    input logic [N-1:0]         fault_mask,
    input logic [N-1:0]         v_w,
    input logic [N-1:0]         e_w,
    input logic [N-1:0][SW-1:0] m_w,
    input logic [N-1:0][SW-1:0] s_w
);
    logic unused_chk;
    assign unused_chk = ^{m_w[N-1], fault_mask[0]};

    // R3
    head_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> v_w[0] == $past(in_valid));

    for (genvar i = 1; i < N; i++) begin : g_chk
        // R3
        step_valid_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> v_w[i] == $past(v_w[i-1]));
        // R4
        shadow_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            v_w[i-1] && e_w[i-1] |=> s_w[i] == $past(s_w[i-1]));
        // R7
        fault_pass_chk: assert property (@(posedge clk) disable iff (rst)
            v_w[i-1] && !e_w[i-1] && fault_mask[i] |=> s_w[i] == $past(m_w[i-1]));
    end

    // R5
    drop_cap_chk: assert property (@(posedge clk) disable iff (rst)
        out_drops <= CW'(N-1));

    // R8
    bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !out_valid |-> $stable(out_sum));
endmodule

bind mac_chain_edrop mac_chain_chk #(.N(N), .SW(SW), .CW($clog2(N)+1)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sum    (out_sum),
    .out_drops  (out_drops),
    .fault_mask (fault_mask),
    .v_w        (v_w),
    .e_w        (e_w),
    .m_w        (m_w),
    .s_w        (s_w)
);

// File: tb/sim_mac_chain_edrop.sv
`timescale 1ns/1ps
module sim_mac_chain_edrop;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_psum = '0;
    logic [31:0] in_act = '0;
    logic [31:0] weights = '0;
    logic [3:0]  fault_mask = '0;
    logic [3:0]  inj_mask = '0;
    logic        out_valid;
    logic [23:0] out_sum;
    logic [2:0]  out_drops;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    bit run = 0;
    logic [23:0] last_sum = '0;

    typedef struct {
        logic [23:0] sum;
        int          drops;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    mac_chain_edrop u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_psum(in_psum),
        .in_act(in_act), .weights(weights), .fault_mask(fault_mask),
        .inj_mask(inj_mask), .out_valid(out_valid), .out_sum(out_sum),
        .out_drops(out_drops)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // expected result straight from R2, R4, R5, R6, R7
    task automatic model(input logic [23:0] ps, input logic [31:0] acts, input logic [3:0] inj,
                         output logic [23:0] s, output int d);
        s = ps;
        d = 0;
        for (int k = 0; k < N; k++) begin
            bit prev_err = (k > 0) && inj[k-1];
            int p = int'($signed(weights[k*8 +: 8])) * int'($signed(acts[k*8 +: 8]));
            if (fault_mask[k]) begin
            end else if (prev_err) begin
                d++;
            end else begin
                s = s + 24'(p);
            end
        end
    endtask

    task automatic send(input logic [23:0] ps, input logic [7:0] a0, input logic [7:0] a1,
                        input logic [7:0] a2, input logic [7:0] a3, input logic [3:0] inj,
                        input string tag);
        exp_t e;
        logic [23:0] s;
        int d;
        @(negedge clk);
        in_valid = 1'b1;
        in_psum  = ps;
        in_act   = {a3, a2, a1, a0};
        inj_mask = inj;
        model(ps, in_act, inj, s, d);
        e.sum = s; e.drops = d; e.due = cyc + N; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_psum  = 24'h123456;
            in_act   = 32'h01010101;
            inj_mask = 4'hF;
        end
    endtask

    task automatic drain();
        idle(N + 3);
        check(sb.size() == 0, "R3 results missing", sb.size(), 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (run && !rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected result", out_sum, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_sum == e.sum, {e.tag, " sum"}, out_sum, e.sum);
                    check(out_drops == 3'(e.drops), {e.tag, " R5 drops"}, out_drops, e.drops);
                    check(cyc == e.due, "R3 latency", cyc, e.due);
                end
                last_sum = out_sum;
            end else begin
                check(out_sum == last_sum, "R8 hold", out_sum, last_sum);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        weights = {8'd7, 8'd5, 8'hFE, 8'd3};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 valid", out_valid, 0);
        check(out_sum == 24'h0, "R1 sum", out_sum, 0);
        check(out_drops == 3'h0, "R1 drops", out_drops, 0);
        run = 1'b1;

        // R2 plain accumulation, back to back (R3)
        send(24'd100, 8'd1, 8'd2, 8'd3, 8'd4, 4'h0, "R2 basic");
        send(24'hFFFFCE, 8'h80, 8'h7F, 8'h00, 8'hFF, 4'h0, "R2 signed");
        send(24'd0, 8'd0, 8'd0, 8'd0, 8'd0, 4'h0, "R2 zero acts");
        send(24'h7FFFFF, 8'd1, 8'd1, 8'd1, 8'd1, 4'h0, "R2 wrap");
        send(24'hFFFFFF, 8'd1, 8'd0, 8'd0, 8'd0, 4'h0, "R2 wrap to low");
        // R4 single errors, R6 last stage
        send(24'd10, 8'd2, 8'd3, 8'd4, 8'd5, 4'b0001, "R4 stage0");
        send(24'd10, 8'd2, 8'd3, 8'd4, 8'd5, 4'b0010, "R4 stage1");
        send(24'd10, 8'd2, 8'd3, 8'd4, 8'd5, 4'b0100, "R4 stage2");
        send(24'd10, 8'd2, 8'd3, 8'd4, 8'd5, 4'b1000, "R6 last");
        // R5 multiple drops
        send(24'd20, 8'hF0, 8'd9, 8'd1, 8'd6, 4'b0011, "R5 adjacent");
        send(24'd20, 8'hF0, 8'd9, 8'd1, 8'd6, 4'b1111, "R5 all");
        send(24'd20, 8'hF0, 8'd9, 8'd1, 8'd6, 4'b0101, "R5 split");
        send(24'd5, 8'd1, 8'd1, 8'd1, 8'd1, 4'b0000, "R5 cleared");
        // R8 bubbles between items
        idle(1);
        send(24'd1, 8'd3, 8'd3, 8'd3, 8'd3, 4'b0000, "R8 gap a");
        idle(3);
        send(24'd2, 8'd4, 8'd0, 8'd4, 8'd0, 4'b0010, "R8 gap b");
        idle(2);
        send(24'd3, 8'd9, 8'd9, 8'd9, 8'd9, 4'b0000, "R8 gap c");
        drain();

        // R7 faulty stages
        weights    = {8'd2, 8'hFD, 8'd11, 8'hF9};
        fault_mask = 4'b0100;
        send(24'd50, 8'd1, 8'd2, 8'd3, 8'd4, 4'b0000, "R7 bypass");
        send(24'd50, 8'd1, 8'd2, 8'd3, 8'd4, 4'b0010, "R7 fwd no drop");
        send(24'd50, 8'd1, 8'd2, 8'd3, 8'd4, 4'b0100, "R7 faulty corrupt");
        drain();
        fault_mask = 4'b1001;
        send(24'd77, 8'd5, 8'd6, 8'd7, 8'd8, 4'b0000, "R7 ends");
        send(24'd77, 8'd5, 8'd6, 8'd7, 8'd8, 4'b0101, "R7 ends err");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule